// File: doc/BRIEF.md
# Gated Edge Count Frequency Meter

This block measures the rate of a pulse train by counting its transitions over a fixed measurement window. The window is timed by an internal counter, so the result is a plain number of edges per window. The caller scales it to a frequency. This suits fast signals, where counting over a known interval resolves better than timing single periods.

A start request, for example from a debounced push button, opens a window when none is running. While the window is open, `gate_on` is high and can drive an indicator lamp. Transitions of the chosen polarity on `sig_in` are counted during the window. When the window closes, the total is latched on `count_out`, `done` pulses for one cycle, and the block waits for the next start.

`sig_in` must already be synchronous to `clk`. The window length is the parameter `GATE_CYCLES`, in clock cycles. The default gives ten seconds at 50 MHz, and a bench can set a short window. The counter width is the parameter `CNT_W`.

Top module: `gated_edge_meter`

## Requirements
- R1: During and right after reset, `gate_on` is 0, `done` is 0 and `count_out` is 0.
- R2: A `start` sampled high while no window is open raises `gate_on` at the next clock edge. `gate_on` then stays high for exactly `GATE_CYCLES` clock cycles.
- R3: With `edge_fall` = 0, each change of `sig_in` from 0 to 1 between two consecutive clock samples inside the window adds one to the count. Changes from 1 to 0 add nothing.
- R4: With `edge_fall` = 1, each change of `sig_in` from 1 to 0 inside the window adds one to the count. Changes from 0 to 1 add nothing.
- R5: A transition is counted only if `gate_on` is high in the cycle that ends with the sample showing the new level. A transition seen in the last open cycle counts. Transitions before the window opens, or after it closes, do not count.
- R6: The count stops at 2^`CNT_W`-1 and does not wrap.
- R7: `done` is high for exactly one cycle, on the same clock edge on which `gate_on` falls. `count_out` takes the window's total on that edge and holds it, whatever `sig_in` does, until the next window closes.
- R8: A `start` while a window is open is ignored. The window is neither extended nor restarted, and edges already counted are kept.
- R9: Opening a window clears the running count, so each result covers only its own window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Signal being measured, already synchronous to `clk` |
| edge_fall | input | 1 | Edge polarity: 0 counts rising edges, 1 counts falling edges; hold it steady during a window |
| start | input | 1 | Request to open a new measurement window |
| gate_on | output | 1 | High while the measurement window is open |
| count_out | output | CNT_W | Edge total of the last completed window |
| done | output | 1 | One-cycle pulse when a window closes and `count_out` is updated |

## Verification
A wrong window timer shows as a `gate_on` pulse of the wrong length, or a `done` that does not fall on the closing edge. It is visible at the first window close, `GATE_CYCLES` cycles after the start. Faults in the edge detector or the running counter stay hidden until `done`. They then show as a wrong `count_out`: off by one at the window edges, the wrong polarity counted, a wrapped value instead of a saturated one, or a total carried over from the previous window. A start taken while the window is open shows as a window longer than `GATE_CYCLES`.

// File: rtl/gem_pkg.sv
package gem_pkg;

  typedef enum logic {
    GATE_IDLE = 1'b0,
    GATE_OPEN = 1'b1
  } gate_state_t;

  // Transition of the chosen polarity between two consecutive samples.
  function automatic logic edge_seen(input logic prev_lvl, input logic cur_lvl,
                                     input logic want_fall);
    if (want_fall) return prev_lvl & ~cur_lvl;
    else           return ~prev_lvl & cur_lvl;
  endfunction

endpackage

// File: rtl/gem_edge_det.sv
module gem_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  input  logic fall,
  output logic hit
);
  import gem_pkg::*;

  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig;
  end

  assign hit = edge_seen(prev_q, sig, fall);

endmodule

// File: rtl/gem_gate_timer.sv
module gem_gate_timer #(
  parameter int GATE_CYCLES = 500_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic gate_open,
  output logic open_evt,
  output logic close_evt
);
  import gem_pkg::*;

  localparam int TW = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(GATE_CYCLES - 1);

  gate_state_t state_q;
  logic [TW-1:0] tmr_q;

  assign gate_open = (state_q == GATE_OPEN);
  assign open_evt  = (state_q == GATE_IDLE) && start;
  assign close_evt = (state_q == GATE_OPEN) && (tmr_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= GATE_IDLE;
      tmr_q   <= '0;
    end else begin
      unique case (state_q)
        GATE_IDLE: begin
          if (open_evt) begin
            state_q <= GATE_OPEN;
            tmr_q   <= '0;
          end
        end
        GATE_OPEN: begin
          if (close_evt) state_q <= GATE_IDLE;
          else           tmr_q   <= tmr_q + 1'b1;
        end
        default: state_q <= GATE_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gem_tally.sv
module gem_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  input  logic             close,
  output logic [CNT_W-1:0] run_cnt,
  output logic [CNT_W-1:0] result,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  logic [CNT_W-1:0] next_cnt;
  assign next_cnt = inc ? sat_inc(run_cnt) : run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      result  <= '0;
      done    <= 1'b0;
    end else begin
      done <= close;
      if (clear) run_cnt <= '0;
      else       run_cnt <= next_cnt;
      if (close) result <= next_cnt;
    end
  end

endmodule

// File: rtl/gated_edge_meter.sv
module gated_edge_meter #(
  parameter int CNT_W       = 16,
  parameter int GATE_CYCLES = 500_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic             edge_fall,
  input  logic             start,
  output logic             gate_on,
  output logic [CNT_W-1:0] count_out,
  output logic             done
);

  // Named internal events, brought out for the checker.
  logic             gate_open;
  logic             open_evt;
  logic             close_evt;
  logic             edge_hit;
  logic             count_en;
  logic [CNT_W-1:0] run_cnt;

  gem_gate_timer #(.GATE_CYCLES(GATE_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .gate_open (gate_open),
    .open_evt  (open_evt),
    .close_evt (close_evt)
  );

  gem_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig   (sig_in),
    .fall  (edge_fall),
    .hit   (edge_hit)
  );

  assign count_en = edge_hit & gate_open;

  gem_tally #(.CNT_W(CNT_W)) u_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (open_evt),
    .inc     (count_en),
    .close   (close_evt),
    .run_cnt (run_cnt),
    .result  (count_out),
    .done    (done)
  );

  assign gate_on = gate_open;

endmodule

// File: rtl/gem_checker.sv
module gem_checker #(
  parameter int CNT_W       = 16,
  parameter int GATE_CYCLES = 500_000_000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             gate_on,
  input logic             done,
  input logic [CNT_W-1:0] count_out,
  input logic             open_evt,
  input logic             close_evt,
  input logic [CNT_W-1:0] run_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [31:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n)       run_len <= '0;
    else if (gate_on) run_len <= run_len + 1'b1;
    else              run_len <= '0;
  end

  assert_gate_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_on) |-> run_len == 32'(GATE_CYCLES));

  assert_open_by_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |-> $past(start));

  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && start && !close_evt) |=> gate_on && !open_evt);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_at_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> done && !gate_on);

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(count_out));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt == CNT_MAX && !open_evt) |=> run_cnt == CNT_MAX);

  assert_clear_on_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    open_evt |=> run_cnt == '0);

endmodule

bind gated_edge_meter gem_checker #(.CNT_W(CNT_W), .GATE_CYCLES(GATE_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .gate_on   (gate_on),
  .done      (done),
  .count_out (count_out),
  .open_evt  (open_evt),
  .close_evt (close_evt),
  .run_cnt   (run_cnt)
);

// File: tb/gated_edge_meter_test.sv
`timescale 1ns/1ps
module gated_edge_meter_test;
  localparam int G = 64;
  localparam int W = 5;

  logic clk = 1'b0, rst_n = 1'b0, sig_in = 1'b0, edge_fall = 1'b0, start = 1'b0;
  logic         gate_on, done;
  logic [W-1:0] count_out;

  always #2.5 clk = ~clk;

  gated_edge_meter #(.CNT_W(W), .GATE_CYCLES(G)) uut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .edge_fall(edge_fall),
    .start(start), .gate_on(gate_on), .count_out(count_out), .done(done)
  );

  typedef struct { int exp; string tag; } item_t;
  item_t sbq[$];
  int n_cmp = 0, n_bad = 0, gate_len = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp,
                       input string what);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Monitor: measure window length, pop expected totals on each done.
  always @(negedge clk) begin
    if (rst_n) begin
      if (gate_on) gate_len++;
      if (done) begin
        check(gate_len == G, "R2", gate_len, G, "window length");
        gate_len = 0;
        if (sbq.size() == 0) check(1'b0, "R7", 1, 0, "done with nothing expected");
        else begin
          item_t it;
          it = sbq.pop_front();
          check(int'(count_out) == it.exp, it.tag, int'(count_out), it.exp, "edge total");
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_gate();
    start = 1'b1;
    step(1);
    start = 1'b0;
  endtask

  task automatic pulse();
    sig_in = 1'b1; step(1);
    sig_in = 1'b0; step(1);
  endtask

  task automatic finish_window();
    while (gate_on) step(1);
    step(2);
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "R2", 0, 1, "watchdog expired");
    report();
  end

  initial begin
    step(1);
    // R1: reset values
    check(gate_on == 1'b0, "R1", gate_on, 0, "gate_on in reset");
    check(done == 1'b0, "R1", done, 0, "done in reset");
    check(count_out == '0, "R1", count_out, 0, "count_out in reset");
    step(2);
    rst_n = 1'b1;
    step(3);
    check(gate_on == 1'b0 && count_out == '0, "R1", gate_on, 0, "idle after reset");

    // R3: rising edges
    edge_fall = 1'b0;
    sbq.push_back('{5, "R3"});
    open_gate();
    check(gate_on == 1'b1, "R2", gate_on, 1, "gate opens after start");
    repeat (5) pulse();
    finish_window();

    // R4: falling edges
    edge_fall = 1'b1;
    sbq.push_back('{7, "R4"});
    open_gate();
    repeat (7) pulse();
    finish_window();

    // R5: edges outside the window, boundary at the last open cycle
    edge_fall = 1'b0;
    repeat (3) pulse();
    sbq.push_back('{1, "R5"});
    open_gate();
    step(G - 1);
    sig_in = 1'b1; step(1);
    sig_in = 1'b0; step(1);
    sig_in = 1'b1; step(1);
    sig_in = 1'b0;
    finish_window();

    // R7: result held while idle with activity on the input
    repeat (4) pulse();
    check(int'(count_out) == 1, "R7", int'(count_out), 1, "held result");
    check(done == 1'b0, "R7", done, 0, "no done while idle");

    // R6: saturation
    sbq.push_back('{(1 << W) - 1, "R6"});
    open_gate();
    repeat (G) begin
      sig_in = ~sig_in;
      step(1);
    end
    sig_in = 1'b0;
    finish_window();

    // R9: fresh window with no edges clears the old total
    sbq.push_back('{0, "R9"});
    open_gate();
    finish_window();

    // R8: start while open is ignored
    sbq.push_back('{5, "R8"});
    open_gate();
    repeat (3) pulse();
    start = 1'b1; step(1); start = 1'b0;
    repeat (2) pulse();
    finish_window();
    check(gate_on == 1'b0, "R8", gate_on, 0, "no restart after close");

    step(4);
    check(sbq.size() == 0, "R7", sbq.size(), 0, "pending results");
    finished = 1;
    report();
  end

endmodule